// File: doc/BRIEF.md
# Near-Lossless Residual Quantizer and Reconstructor

This block sits between a sample predictor and an entropy coder in a near-lossless image compression path. For each sample it receives the original sample value, the predicted value for that sample and the error-limit settings of the current spectral band. From these it forms the prediction residual, quantizes it into a signed index with a uniform odd-width bin, rebuilds the clipped bin center that a decoder would also see, and folds the index into an unsigned mapped residual for the coder.

The permitted error for a sample can come from a fixed absolute limit, from a relative limit that scales with the predicted value, from the tighter of the two, or it can be forced to zero for lossless operation. None of the divisions by the bin width uses a hardware divider. Each one multiplies by a reciprocal that is rounded upward and read from a constant table indexed by the error limit. Samples enter and leave through valid/ready handshakes. A two-stage pipeline gives a latency of two accepted cycles.

Top module: `nlq_residual_quant`

## Requirements
- R1: The residual is `in_sample - in_pred` (samples are unsigned, D = SAMP_W bits). The index `out_qidx` is a (D+1)-bit two's complement value equal to sign(residual) · floor((|residual| + m) / (2m + 1)). m is the maximum error for the sample.
- R2: With `in_mode` = 2'b00 (absolute), m equals `in_abs`.
- R3: With `in_mode` = 2'b01 (relative), m equals floor(`in_rel` · `in_pred` / 2^D).
- R4: With `in_mode` = 2'b10 (combined), m is the smaller of the absolute and relative values. With `in_mode` = 2'b11, m is zero.
- R5: When m is zero (from any mode), `out_qidx` equals the residual exactly.
- R6: `out_center` equals `in_pred` + q·(2m+1), clipped to the range 0 to 2^D − 1.
- R7: |`in_sample` − `out_center`| never exceeds m.
- R8: With θ = min(floor((ŝ + m)/(2m+1)), floor((2^D − 1 − ŝ + m)/(2m+1))) and ŝ = `in_pred`, `out_mapped` is |q| + θ when |q| > θ. Otherwise it is 2|q| when q ≥ 0 for an even ŝ or q ≤ 0 for an odd ŝ, and 2|q| − 1 in the other cases.
- R9: Every division by 2m+1 is computed as a multiply by a rounded-up reciprocal. The table holds one entry for each m from 1 to 2^max(ABS_W, REL_W) − 1. The quotient equals exact floor division for every such m and for numerators across the full residual range.
- R10: An input is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on `out_valid` after the second such edge with no stall. While `out_valid` is high and `out_ready` is low, the output is held unchanged. With both pipeline stages full and the output stalled, `in_ready` is low. Results leave in input order.
- R11: After a synchronous active-high reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_mode | input | 2 | Error-limit selection: 00 absolute, 01 relative, 10 combined, 11 lossless |
| in_abs | input | ABS_W | Absolute error limit of the band |
| in_rel | input | REL_W | Relative error limit of the band |
| in_sample | input | SAMP_W | Original sample |
| in_pred | input | SAMP_W | Predicted sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_qidx | output | SAMP_W+1 | Signed quantizer index |
| out_center | output | SAMP_W | Clipped bin center |
| out_mapped | output | SAMP_W | Unsigned mapped residual |

## Verification
On every cycle the embedded properties check the following: each reciprocal quotient brackets its numerator between d·q and d·(q+1), the bin center stays within m of the sample, a zero limit passes the residual through unchanged, the index carries the residual's sign, the mapped value fits its field, and a stalled output stays stable. Other behaviour needs the bench's scenarios to show it. This covers the choice of m in each mode, the clipping at both range ends, the exact folding of the mapped residual for even and odd predictions, the two-cycle latency, and `in_ready` dropping with a full pipeline. The bench also sweeps every table entry against true division at the residual extremes.

// File: rtl/qnt_pkg.sv
package qnt_pkg;

    typedef enum logic [1:0] {
        LIM_ABS  = 2'd0,
        LIM_REL  = 2'd1,
        LIM_BOTH = 2'd2,
        LIM_NONE = 2'd3
    } lim_mode_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Reciprocal of an odd divisor, scaled by 2^shift and rounded upward.
    function automatic logic [63:0] recip_up(int shift, int divisor);
        logic [63:0] scaled;
        scaled = 64'd1 << shift;
        return (scaled + 64'(divisor) - 64'd1) / 64'(divisor);
    endfunction

endpackage

// File: rtl/qnt_err_limit.sv
module qnt_err_limit
    import qnt_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int ABS_W  = 6,
    parameter int REL_W  = 6
) (
    input  lim_mode_e                              mode,
    input  logic [ABS_W-1:0]                       abs_lim,
    input  logic [REL_W-1:0]                       rel_lim,
    input  logic [SAMP_W-1:0]                      pred,
    output logic [imax(ABS_W, REL_W)-1:0]          m_out
);
    localparam int M_W    = imax(ABS_W, REL_W);
    localparam int PROD_W = REL_W + SAMP_W;

    logic [M_W-1:0] m_abs;
    logic [M_W-1:0] m_rel;

    always_comb begin
        m_abs = M_W'(abs_lim);
        m_rel = M_W'(REL_W'((PROD_W'(rel_lim) * PROD_W'(pred)) >> SAMP_W));
        unique case (mode)
            LIM_ABS:  m_out = m_abs;
            LIM_REL:  m_out = m_rel;
            LIM_BOTH: m_out = (m_abs < m_rel) ? m_abs : m_rel;
            default:  m_out = '0;
        endcase
    end

endmodule

// File: rtl/qnt_recip_div.sv
module qnt_recip_div
    import qnt_pkg::*;
#(
    parameter int NUM_W = 17,
    parameter int M_W   = 6
) (
    input  logic [NUM_W-1:0] num,
    input  logic [M_W-1:0]   m,
    output logic [NUM_W-1:0] quo
);
    localparam int TBL_N  = (1 << M_W) - 1;
    localparam int SHIFT  = NUM_W + M_W + 1;
    localparam int RCP_W  = SHIFT;
    localparam int PROD_W = NUM_W + RCP_W;

    logic [RCP_W-1:0] rcp_tbl [0:TBL_N];
    logic [RCP_W-1:0] rcp;

    assign rcp_tbl[0] = '0;
    for (genvar k = 1; k <= TBL_N; k++) begin : g_tbl
        assign rcp_tbl[k] = RCP_W'(recip_up(SHIFT, 2 * k + 1));
    end

    always_comb begin
        rcp = rcp_tbl[m];
        if (m == '0) begin
            quo = num;
        end else begin
            quo = NUM_W'((PROD_W'(num) * PROD_W'(rcp)) >> SHIFT);
        end
    end

endmodule

// File: rtl/qnt_mapper.sv
module qnt_mapper #(
    parameter int NUM_W = 17
) (
    input  logic signed [NUM_W-1:0] q,
    input  logic [NUM_W-1:0]        theta,
    input  logic                    pred_odd,
    output logic [NUM_W:0]          mapped
);
    logic [NUM_W-1:0] q_mag;
    logic             q_neg;
    logic             toward;

    always_comb begin
        q_neg  = q[NUM_W-1];
        q_mag  = q_neg ? NUM_W'(-q) : NUM_W'(q);
        toward = pred_odd ? (q_neg || (q == '0)) : !q_neg;
        if (q_mag > theta) begin
            mapped = {1'b0, q_mag} + {1'b0, theta};
        end else if (toward) begin
            mapped = {q_mag, 1'b0};
        end else begin
            mapped = {q_mag, 1'b0} - 1'b1;
        end
    end

endmodule

// File: rtl/nlq_residual_quant.sv
module nlq_residual_quant
    import qnt_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int ABS_W  = 6,
    parameter int REL_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_mode,
    input  logic [ABS_W-1:0]         in_abs,
    input  logic [REL_W-1:0]         in_rel,
    input  logic [SAMP_W-1:0]        in_sample,
    input  logic [SAMP_W-1:0]        in_pred,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [SAMP_W:0]   out_qidx,
    output logic [SAMP_W-1:0]        out_center,
    output logic [SAMP_W-1:0]        out_mapped
);
    localparam int M_W   = imax(ABS_W, REL_W);
    localparam int NUM_W = SAMP_W + 1;
    localparam int D_W   = M_W + 1;
    localparam int C_W   = NUM_W + D_W + 2;
    localparam int N_DIV = 3;
    localparam logic [SAMP_W-1:0] SMAX = '1;

    typedef struct packed {
        logic                    neg;
        logic [NUM_W-1:0]        num_q;
        logic [NUM_W-1:0]        num_lo;
        logic [NUM_W-1:0]        num_hi;
        logic [M_W-1:0]          m;
        logic [SAMP_W-1:0]       pred;
        logic [SAMP_W-1:0]       samp;
        logic signed [NUM_W-1:0] resid;
    } stage1_t;

    typedef struct packed {
        logic signed [NUM_W-1:0] q;
        logic [SAMP_W-1:0]       center;
        logic [SAMP_W-1:0]       mapped;
        logic [SAMP_W-1:0]       samp;
        logic [M_W-1:0]          m;
        logic signed [NUM_W-1:0] resid;
    } stage2_t;

    // ---------------- handshake ----------------
    logic s1_v, o_v;
    logic s1_ready, s2_ready;

    assign s2_ready  = !o_v || out_ready;
    assign s1_ready  = !s1_v || s2_ready;
    assign in_ready  = s1_ready;
    assign out_valid = o_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
            o_v  <= 1'b0;
        end else begin
            if (s1_ready) s1_v <= in_valid;
            if (s2_ready) o_v  <= s1_v;
        end
    end

    // ---------------- stage 0: residual and error limit ----------------
    lim_mode_e               mode_c;
    logic [M_W-1:0]          m_c;
    logic signed [NUM_W-1:0] resid_c;
    logic [NUM_W-1:0]        mag_c;
    stage1_t                 s1_n, s1_q;

    assign mode_c = lim_mode_e'(in_mode);

    qnt_err_limit #(
        .SAMP_W (SAMP_W),
        .ABS_W  (ABS_W),
        .REL_W  (REL_W)
    ) u_lim (
        .mode    (mode_c),
        .abs_lim (in_abs),
        .rel_lim (in_rel),
        .pred    (in_pred),
        .m_out   (m_c)
    );

    always_comb begin
        resid_c     = $signed({1'b0, in_sample}) - $signed({1'b0, in_pred});
        mag_c       = resid_c[NUM_W-1] ? NUM_W'(-resid_c) : NUM_W'(resid_c);
        s1_n.neg    = resid_c[NUM_W-1];
        s1_n.num_q  = mag_c + NUM_W'(m_c);
        s1_n.num_lo = NUM_W'(in_pred) + NUM_W'(m_c);
        s1_n.num_hi = NUM_W'(SMAX - in_pred) + NUM_W'(m_c);
        s1_n.m      = m_c;
        s1_n.pred   = in_pred;
        s1_n.samp   = in_sample;
        s1_n.resid  = resid_c;
    end

    always_ff @(posedge clk) begin
        if (s1_ready && in_valid) s1_q <= s1_n;
    end

    // ---------------- stage 1: reciprocal dividers ----------------
    logic [NUM_W-1:0] div_num [N_DIV];
    logic [NUM_W-1:0] div_quo [N_DIV];
    logic [D_W-1:0]   d_c;

    assign d_c        = {s1_q.m, 1'b1};
    assign div_num[0] = s1_q.num_q;
    assign div_num[1] = s1_q.num_lo;
    assign div_num[2] = s1_q.num_hi;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        qnt_recip_div #(
            .NUM_W (NUM_W),
            .M_W   (M_W)
        ) u_div (
            .num (div_num[g]),
            .m   (s1_q.m),
            .quo (div_quo[g])
        );

        AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
            s1_v |-> ((32'(div_quo[g]) * 32'(d_c) <= 32'(div_num[g])) &&
                      (32'(div_num[g]) < (32'(div_quo[g]) + 32'd1) * 32'(d_c)))); // R9
    end

    // ---------------- stage 1: index, center, mapping ----------------
    logic signed [NUM_W-1:0] q_c;
    logic [NUM_W-1:0]        theta_c;
    logic signed [C_W-1:0]   ctr_raw;
    logic [SAMP_W-1:0]       ctr_c;
    logic [NUM_W:0]          map_wide;
    stage2_t                 s2_n, o_q;

    always_comb begin
        q_c     = s1_q.neg ? $signed(NUM_W'(-div_quo[0])) : $signed(div_quo[0]);
        theta_c = (div_quo[1] < div_quo[2]) ? div_quo[1] : div_quo[2];
        ctr_raw = $signed({{(C_W-SAMP_W){1'b0}}, s1_q.pred})
                + C_W'(q_c) * $signed({{(C_W-D_W){1'b0}}, d_c});
        if (ctr_raw < 0) begin
            ctr_c = '0;
        end else if (ctr_raw > $signed({{(C_W-SAMP_W){1'b0}}, SMAX})) begin
            ctr_c = SMAX;
        end else begin
            ctr_c = ctr_raw[SAMP_W-1:0];
        end
    end

    qnt_mapper #(
        .NUM_W (NUM_W)
    ) u_map (
        .q        (q_c),
        .theta    (theta_c),
        .pred_odd (s1_q.pred[0]),
        .mapped   (map_wide)
    );

    AST_MAP_FITS: assert property (@(posedge clk) disable iff (rst)
        s1_v |-> (map_wide[NUM_W:SAMP_W] == '0)); // R8

    always_comb begin
        s2_n.q      = q_c;
        s2_n.center = ctr_c;
        s2_n.mapped = map_wide[SAMP_W-1:0];
        s2_n.samp   = s1_q.samp;
        s2_n.m      = s1_q.m;
        s2_n.resid  = s1_q.resid;
    end

    always_ff @(posedge clk) begin
        if (s2_ready && s1_v) o_q <= s2_n;
    end

    assign out_qidx   = o_q.q;
    assign out_center = o_q.center;
    assign out_mapped = o_q.mapped;

    // ---------------- output-side properties ----------------
    logic [SAMP_W-1:0] err_mag;
    assign err_mag = (o_q.samp > o_q.center) ? (o_q.samp - o_q.center)
                                             : (o_q.center - o_q.samp);

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_qidx) &&
                                       $stable(out_center) && $stable(out_mapped))); // R10

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (err_mag <= SAMP_W'(o_q.m))); // R7

    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (o_q.m == '0)) |-> (o_q.q == o_q.resid)); // R5

    AST_INDEX_SIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (o_q.q != '0)) |-> (o_q.q[NUM_W-1] == o_q.resid[NUM_W-1])); // R1

endmodule

// File: tb/nlq_residual_quant_tb_top.sv
module nlq_residual_quant_tb_top;

    localparam int SW   = 16;
    localparam int AW   = 6;
    localparam int RW   = 6;
    localparam int SMAX = (1 << SW) - 1;
    localparam int MMAX = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                 in_valid  = 1'b0;
    logic                 in_ready;
    logic [1:0]           in_mode   = '0;
    logic [AW-1:0]        in_abs    = '0;
    logic [RW-1:0]        in_rel    = '0;
    logic [SW-1:0]        in_sample = '0;
    logic [SW-1:0]        in_pred   = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic signed [SW:0]   out_qidx;
    logic [SW-1:0]        out_center;
    logic [SW-1:0]        out_mapped;

    nlq_residual_quant #(.SAMP_W(SW), .ABS_W(AW), .REL_W(RW)) dut_i (
        .clk, .rst, .in_valid, .in_ready, .in_mode, .in_abs, .in_rel,
        .in_sample, .in_pred, .out_valid, .out_ready, .out_qidx,
        .out_center, .out_mapped
    );

    typedef struct {
        int    q;
        int    c;
        int    mp;
        int    m;
        int    s;
        string tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          rdy_mode = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    logic [31:0] st   = 32'h9e37_79b9;

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step(logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic exp_t model(int mode, int a, int r, int s, int p, string tag);
        exp_t e;
        int m, mr, d, dl, q, c, th1, th2, th, aq, mp;
        mr = (r * p) >>> SW;
        case (mode)
            0:       m = a;
            1:       m = mr;
            2:       m = (a < mr) ? a : mr;
            default: m = 0;
        endcase
        d  = 2 * m + 1;
        dl = s - p;
        if (dl < 0) q = -((-dl + m) / d);
        else        q = (dl + m) / d;
        c = p + q * d;
        if (c < 0)    c = 0;
        if (c > SMAX) c = SMAX;
        th1 = (p + m) / d;
        th2 = (SMAX - p + m) / d;
        th  = (th1 < th2) ? th1 : th2;
        aq  = (q < 0) ? -q : q;
        if (aq > th)                                          mp = aq + th;
        else if (((p % 2 == 0) && q >= 0) || ((p % 2 == 1) && q <= 0)) mp = 2 * aq;
        else                                                  mp = 2 * aq - 1;
        e.q = q; e.c = c; e.mp = mp; e.m = m; e.s = s; e.tag = tag;
        return e;
    endfunction

    // monitor: sets ready, then compares the item leaving at the next edge
    always @(negedge clk) begin
        exp_t e;
        int   err;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                out_ready = lfsr[0] | lfsr[1];
            end
        endcase
        if (!rst && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                chk("R10", 1, 0, "unexpected output");
            end else begin
                e = sb.pop_front();
                chk(e.tag, int'(out_qidx), e.q, "qidx");
                chk(e.tag, int'(out_center), e.c, "center");
                chk(e.tag, int'(out_mapped), e.mp, "mapped");
                err = e.s - int'(out_center);
                if (err < 0) err = -err;
                chk("R7", int'(err <= e.m), 1, "error bound");
            end
        end
    end

    // driver: called at negedge+2, returns at negedge+2 after acceptance
    task automatic send(int mode, int a, int r, int s, int p, string tag);
        in_valid  = 1'b1;
        in_mode   = 2'(mode);
        in_abs    = AW'(a);
        in_rel    = RW'(r);
        in_sample = SW'(s);
        in_pred   = SW'(p);
        while (!in_ready) begin
            @(negedge clk); #2;
        end
        sb.push_back(model(mode, a, r, s, p, tag));
        @(negedge clk); #2;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) begin
            @(negedge clk); #2;
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int held_q;
        repeat (4) @(negedge clk);
        #2 rst = 1'b0;
        @(negedge clk); #2;
        chk("R11", int'(out_valid), 0, "out_valid after reset");
        chk("R11", int'(in_ready), 1, "in_ready after reset");

        // R10: two-edge latency with the consumer always ready
        in_valid = 1'b1; in_mode = 2'd3; in_sample = SW'(100); in_pred = SW'(90);
        sb.push_back(model(3, 0, 0, 100, 90, "R10"));
        @(negedge clk); #2;
        in_valid = 1'b0;
        chk("R10", int'(out_valid), 0, "valid one edge after accept");
        @(negedge clk); #2;
        chk("R10", int'(out_valid), 1, "valid two edges after accept");
        drain();

        // R1 / R5: lossless patterns, both signs, both prediction parities
        send(3, 0, 0, 500, 500, "R5");
        send(3, 0, 0, 1000, 10, "R1");
        send(3, 0, 0, 10, 1000, "R1");
        send(3, 0, 0, SMAX, 0, "R1");
        send(3, 0, 0, 0, SMAX, "R1");
        send(3, 0, 0, 7, 5, "R8");
        send(3, 0, 0, 3, 5, "R8");
        send(3, 0, 0, 8, 6, "R8");
        send(3, 0, 0, 4, 6, "R8");
        send(0, 0, 0, 1234, 4321, "R5");
        send(1, 0, 40, 777, 100, "R5");

        // R2 absolute, R3 relative, R4 combined and forced lossless
        send(0, 5, 0, 300, 280, "R2");
        send(0, 17, 63, 200, 260, "R2");
        send(1, 0, 63, 40000, 60000, "R3");
        send(1, 9, 32, 1000, 50000, "R3");
        send(2, 10, 63, 40000, 60000, "R4");
        send(2, 63, 20, 30000, 65000, "R4");
        send(3, 63, 63, 30000, 30100, "R4");

        // R6: clipping at the top and bottom of the range
        send(0, 20, 0, SMAX, 65500, "R6");
        send(0, 20, 0, 0, 30, "R6");
        send(0, 63, 0, SMAX, 65470, "R6");
        send(0, 63, 0, 0, 60, "R6");

        // R9: every table entry at the residual extremes and mid-range
        for (int m = 1; m <= MMAX; m++) begin
            send(0, m, 0, SMAX, 0, "R9");
            send(0, m, 0, 0, SMAX, "R9");
            st = step(st);
            send(0, m, 0, int'(st[15:0]), int'(st[31:16]), "R9");
        end
        drain();

        // R10: stall holds the output and fills the pipeline
        rdy_mode = 1;
        @(negedge clk); #2;
        send(0, 3, 0, 5000, 4000, "R10");
        send(0, 4, 0, 100, 2000, "R10");
        chk("R10", int'(in_ready), 0, "in_ready with full pipeline");
        held_q = int'(out_qidx);
        repeat (3) begin
            @(negedge clk); #2;
        end
        chk("R10", int'(out_valid), 1, "valid held under stall");
        chk("R10", int'(out_qidx), held_q, "qidx held under stall");
        chk("R10", int'(out_qidx), sb[0].q, "oldest item at output");
        rdy_mode = 0;
        drain();

        // R8: pseudo-random stream with random back-pressure
        rdy_mode = 2;
        for (int i = 0; i < 300; i++) begin
            st = step(st);
            send(int'(st[1:0]), int'(st[7:2]), int'(st[13:8]),
                 int'(step(st) & 32'hffff), int'((step(st) >> 16) & 32'hffff), "R8");
        end
        rdy_mode = 0;
        drain();
        repeat (3) @(negedge clk);
        chk("R10", sb.size(), 0, "results outstanding at end");
        summary();
        $finish;
    end

endmodule